// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Victim Buffer

This block is a small write-back data cache. Its main store is a direct-mapped array, so every address has exactly one slot. A small fully associative buffer sits beside the array. The buffer keeps lines that the array has recently evicted, so two addresses that fight over one slot can both stay on chip. Each read or write looks up the array and every buffer entry at the same time. When the array hits, the access completes at once. When only the buffer hits, the buffer line and the array line trade places in a single step, with no lower-level traffic. When both miss, the line is fetched from the next memory level over a request/ready handshake that moves one full line per transfer. The line that the array gives up moves into the buffer. If that move pushes a dirty buffer line out, the dirty line is written back first.

The processor side takes one request at a time while `cpuReady` is high and returns the word through a one-cycle response strobe. Three free-running counters report primary hits, buffer hits and full misses.

Top module: `victim_cache`

## Requirements
- R1: After reset, every array line and buffer entry is invalid. `cpuReady` is high, `cpuRespValid` and `memReq` are low, and all three counters read zero.
- R2: When a request is accepted (`cpuValid` and `cpuReady` both high at a rising edge) and it hits the array, `cpuRespValid` rises in the next cycle, no memory transfer takes place, and the primary-hit counter increments.
- R3: When an accepted request misses the array but hits a buffer entry, the two lines exchange places. `cpuReady` is low in the cycle after acceptance, and the response comes one cycle later than a primary hit. There is no memory transfer, and the buffer-hit counter increments.
- R4: When an accepted request misses both structures, one line read is made from the lower level and the line is installed in the array. The line the array held moves into the buffer, the response follows the returned line by one cycle, and the miss counter increments.
- R5: Buffer placement uses an empty entry while one exists. Otherwise it displaces the entry whose last fill or swap is the oldest. Entries that are not displaced remain hittable.
- R6: A lower-level write happens only when a dirty buffer entry is displaced, and it carries that entry's line address and data. A clean entry is dropped silently. The array never writes to memory directly.
- R7: Write-allocate: a write miss fetches the line, merges the written word and marks the line dirty. Later reads return the written word, and no write reaches memory until that line is displaced from the buffer.
- R8: `memReq` stays high with `memWrite`, `memAddr` and `memWdata` stable until the cycle in which `memReady` is high. Read data on `memRdata` is taken in that cycle.
- R9: Addresses are word addresses. Bits [1:0] select the word in a four-word line, bits [4:2] select the array slot, and the upper bits are the tag. `memAddr` is the line address, i.e. `cpuAddr[15:2]`.
- R10: The dirty bit travels with a line between the array and the buffer. A line written in the array, swapped out and later displaced from the buffer is written back with the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuValid | input | 1 | Processor request present |
| cpuWrite | input | 1 | Request is a write |
| cpuAddr | input | 16 | Word address of the request |
| cpuWdata | input | 32 | Write data |
| cpuReady | output | 1 | Block can accept a request this cycle |
| cpuRespValid | output | 1 | One-cycle strobe: `cpuRdata` holds the result |
| cpuRdata | output | 32 | Word read, or the word just written |
| memReq | output | 1 | Lower-level transfer requested |
| memWrite | output | 1 | Transfer is a line write-back |
| memAddr | output | 14 | Line address of the transfer |
| memWdata | output | 128 | Line written back |
| memReady | input | 1 | Lower level completes the transfer this cycle |
| memRdata | input | 128 | Line returned for a read transfer |
| statPrimHits | output | 16 | Count of primary-array hits |
| statVictimHits | output | 16 | Count of buffer hits |
| statMisses | output | 16 | Count of full misses |

## Verification
Some properties are checked on every cycle. An address never hits the array and the buffer together. An accepted primary hit always answers on the next cycle. A buffer hit always drops `cpuReady` for one cycle and then answers. A returned line always produces a response. A pending memory request holds its command steady. Every write-back comes from a valid dirty entry. The age order of the buffer always names exactly one oldest entry.

Other behaviours are visible only across a sequence of accesses, so the directed scenarios cover them. These are the correct data after swaps and refills, the choice of which buffer entry is displaced, the presence or absence of a write-back, and a dirty word surviving a trip through the buffer and out to memory.

// File: rtl/vcache_pkg.sv
package vcache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SWAP,
    ST_WBACK,
    ST_FETCH
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic useLive;     // look up the live processor inputs
    logic latchReq;    // capture request and chosen buffer slot
    logic doPrimary;   // complete an array hit
    logic doSwap;      // exchange buffer entry and array line
    logic doFill;      // install the returned line
    logic selWback;    // memory port shows the displaced entry
    logic incPrimary;
    logic incVictim;
    logic incMiss;
  } ctrlStrobe_t;

  // lookup results from datapath to control
  typedef struct packed {
    logic primHit;
    logic vbHit;
    logic needWback;
  } dpStatus_t;

endpackage

// File: rtl/vcache_lru.sv
module vcache_lru #(
  parameter int DEPTH = 4,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             touch,
  input  logic [IW-1:0]    touchIdx,
  input  logic [DEPTH-1:0] validVec,
  output logic [IW-1:0]    pickIdx
);

  logic [IW-1:0] age [DEPTH];
  logic [DEPTH-1:0] oldestVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) age[i] <= IW'(i);
    end else if (touch) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (IW'(i) == touchIdx) age[i] <= '0;
        else if (age[i] < age[touchIdx]) age[i] <= age[i] + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_oldest
    assign oldestVec[g] = (age[g] == IW'(DEPTH - 1));
  end

  // empty entry first, otherwise the oldest one
  always_comb begin
    logic found;
    found   = 1'b0;
    pickIdx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!validVec[i] && !found) begin
        pickIdx = IW'(i);
        found   = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (oldestVec[i]) pickIdx = IW'(i);
      end
    end
  end

  p_one_oldest_r5: assert property (@(posedge clk) disable iff (!rstN)
    $countones(oldestVec) == 1);

endmodule

// File: rtl/vcache_ctrl.sv
module vcache_ctrl
  import vcache_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuValid,
  input  dpStatus_t   status,
  input  logic        memReady,
  output logic        cpuReady,
  output logic        memReq,
  output logic        memWrite,
  output ctrlStrobe_t strobe
);

  ctrlState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    cpuReady  = 1'b0;
    memReq    = 1'b0;
    memWrite  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        cpuReady       = 1'b1;
        strobe.useLive = 1'b1;
        if (cpuValid) begin
          strobe.latchReq = 1'b1;
          if (status.primHit) begin
            strobe.doPrimary  = 1'b1;
            strobe.incPrimary = 1'b1;
          end else if (status.vbHit) begin
            strobe.incVictim = 1'b1;
            nextState        = ST_SWAP;
          end else begin
            strobe.incMiss = 1'b1;
            nextState      = status.needWback ? ST_WBACK : ST_FETCH;
          end
        end
      end
      ST_SWAP: begin
        strobe.doSwap = 1'b1;
        nextState     = ST_IDLE;
      end
      ST_WBACK: begin
        memReq          = 1'b1;
        memWrite        = 1'b1;
        strobe.selWback = 1'b1;
        if (memReady) nextState = ST_FETCH;
      end
      ST_FETCH: begin
        memReq = 1'b1;
        if (memReady) begin
          strobe.doFill = 1'b1;
          nextState     = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  p_swap_no_mem_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doSwap |-> !memReq && !cpuReady);

endmodule

// File: rtl/vcache_dp.sv
module vcache_dp
  import vcache_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 8,
  parameter int VB_DEPTH   = 4,
  parameter int CNT_W      = 16,
  localparam int OFF_W   = $clog2(LINE_WORDS),
  localparam int IDX_W   = $clog2(SETS),
  localparam int TAG_W   = ADDR_W - OFF_W - IDX_W,
  localparam int LADDR_W = ADDR_W - OFF_W,
  localparam int LINE_W  = WORD_W * LINE_WORDS
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cpuWrite,
  input  logic [ADDR_W-1:0]  cpuAddr,
  input  logic [WORD_W-1:0]  cpuWdata,
  input  ctrlStrobe_t        strobe,
  output dpStatus_t          status,
  output logic [LADDR_W-1:0] memAddr,
  output logic [LINE_W-1:0]  memWdata,
  input  logic [LINE_W-1:0]  memRdata,
  output logic               respValid,
  output logic [WORD_W-1:0]  rdata,
  output logic [CNT_W-1:0]   cntPrimary,
  output logic [CNT_W-1:0]   cntVictim,
  output logic [CNT_W-1:0]   cntMiss
);

  localparam int VB_IW = (VB_DEPTH > 1) ? $clog2(VB_DEPTH) : 1;

  // captured request
  logic              reqWrite;
  logic [ADDR_W-1:0] reqAddr;
  logic [WORD_W-1:0] reqWdata;
  logic [VB_IW-1:0]  tgtReg;

  // primary array
  logic [TAG_W-1:0]  tagArr  [SETS];
  logic [LINE_W-1:0] dataArr [SETS];
  logic [SETS-1:0]   validArr, dirtyArr;

  // victim buffer
  logic [LADDR_W-1:0] vbTag  [VB_DEPTH];
  logic [LINE_W-1:0]  vbData [VB_DEPTH];
  logic [VB_DEPTH-1:0] vbValid, vbDirty, vbMatch;

  // operand selection
  logic              opWrite;
  logic [ADDR_W-1:0] opAddr;
  logic [WORD_W-1:0] opWdata;
  logic [OFF_W-1:0]  opOff;
  logic [IDX_W-1:0]  opIdx;
  logic [TAG_W-1:0]  opTag;
  logic [LADDR_W-1:0] opLine;

  assign opWrite = strobe.useLive ? cpuWrite : reqWrite;
  assign opAddr  = strobe.useLive ? cpuAddr  : reqAddr;
  assign opWdata = strobe.useLive ? cpuWdata : reqWdata;
  assign opOff   = opAddr[OFF_W-1:0];
  assign opIdx   = opAddr[OFF_W +: IDX_W];
  assign opTag   = opAddr[ADDR_W-1 -: TAG_W];
  assign opLine  = opAddr[ADDR_W-1:OFF_W];

  // lookups
  logic primHit, vbHit;
  logic [VB_IW-1:0] vbHitIdx, tgtPick;

  assign primHit = validArr[opIdx] && (tagArr[opIdx] == opTag);

  for (genvar g = 0; g < VB_DEPTH; g++) begin : g_cmp
    assign vbMatch[g] = vbValid[g] && (vbTag[g] == opLine);
  end

  assign vbHit = |vbMatch;

  always_comb begin
    vbHitIdx = '0;
    for (int i = 0; i < VB_DEPTH; i++) begin
      if (vbMatch[i]) vbHitIdx = VB_IW'(i);
    end
  end

  // replacement order
  logic lruTouch;
  logic [VB_IW-1:0] lruIdx;

  assign lruTouch = strobe.doSwap || (strobe.doFill && validArr[opIdx]);
  assign lruIdx   = strobe.doSwap ? vbHitIdx : tgtReg;

  vcache_lru #(.DEPTH(VB_DEPTH)) uLru (
    .clk      (clk),
    .rstN     (rstN),
    .touch    (lruTouch),
    .touchIdx (lruIdx),
    .validVec (vbValid),
    .pickIdx  (tgtPick)
  );

  assign status.primHit   = primHit;
  assign status.vbHit     = vbHit;
  assign status.needWback = validArr[opIdx] && vbValid[tgtPick] && vbDirty[tgtPick];

  // line merge
  logic [LINE_W-1:0] srcLine, mergedLine;
  logic [WORD_W-1:0] respWord;

  always_comb begin
    if (strobe.doFill)      srcLine = memRdata;
    else if (strobe.doSwap) srcLine = vbData[vbHitIdx];
    else                    srcLine = dataArr[opIdx];
    mergedLine = srcLine;
    for (int w = 0; w < LINE_WORDS; w++) begin
      if (opWrite && (opOff == OFF_W'(w))) mergedLine[w*WORD_W +: WORD_W] = opWdata;
    end
    respWord = mergedLine[opOff*WORD_W +: WORD_W];
  end

  logic install;
  assign install = strobe.doPrimary || strobe.doSwap || strobe.doFill;

  // state with reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validArr   <= '0;
      dirtyArr   <= '0;
      vbValid    <= '0;
      vbDirty    <= '0;
      respValid  <= 1'b0;
      rdata      <= '0;
      reqWrite   <= 1'b0;
      reqAddr    <= '0;
      reqWdata   <= '0;
      tgtReg     <= '0;
      cntPrimary <= '0;
      cntVictim  <= '0;
      cntMiss    <= '0;
    end else begin
      respValid <= install;
      if (strobe.latchReq) begin
        reqWrite <= cpuWrite;
        reqAddr  <= cpuAddr;
        reqWdata <= cpuWdata;
        tgtReg   <= tgtPick;
      end
      if (strobe.incPrimary) cntPrimary <= cntPrimary + 1'b1;
      if (strobe.incVictim)  cntVictim  <= cntVictim + 1'b1;
      if (strobe.incMiss)    cntMiss    <= cntMiss + 1'b1;
      if (install) begin
        rdata           <= respWord;
        validArr[opIdx] <= 1'b1;
      end
      if (strobe.doPrimary) dirtyArr[opIdx] <= dirtyArr[opIdx] | opWrite;
      if (strobe.doSwap) begin
        dirtyArr[opIdx]   <= vbDirty[vbHitIdx] | opWrite;
        vbValid[vbHitIdx] <= validArr[opIdx];
        vbDirty[vbHitIdx] <= validArr[opIdx] & dirtyArr[opIdx];
      end
      if (strobe.doFill) begin
        dirtyArr[opIdx] <= opWrite;
        if (validArr[opIdx]) begin
          vbValid[tgtReg] <= 1'b1;
          vbDirty[tgtReg] <= dirtyArr[opIdx];
        end
      end
    end
  end

  // storage without reset
  always_ff @(posedge clk) begin
    if (install) begin
      dataArr[opIdx] <= mergedLine;
      tagArr[opIdx]  <= opTag;
    end
    if (strobe.doSwap) begin
      vbTag[vbHitIdx]  <= {tagArr[opIdx], opIdx};
      vbData[vbHitIdx] <= dataArr[opIdx];
    end
    if (strobe.doFill && validArr[opIdx]) begin
      vbTag[tgtReg]  <= {tagArr[opIdx], opIdx};
      vbData[tgtReg] <= dataArr[opIdx];
    end
  end

  assign memAddr  = strobe.selWback ? vbTag[tgtReg] : reqAddr[ADDR_W-1:OFF_W];
  assign memWdata = vbData[tgtReg];

  p_excl_hit_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(primHit && vbHit));

  p_wb_dirty_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.selWback |-> vbValid[tgtReg] && vbDirty[tgtReg]);

endmodule

// File: rtl/victim_cache.sv
module victim_cache
  import vcache_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 8,
  parameter int VB_DEPTH   = 4,
  parameter int CNT_W      = 16,
  localparam int OFF_W   = $clog2(LINE_WORDS),
  localparam int LADDR_W = ADDR_W - OFF_W,
  localparam int LINE_W  = WORD_W * LINE_WORDS
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cpuValid,
  input  logic               cpuWrite,
  input  logic [ADDR_W-1:0]  cpuAddr,
  input  logic [WORD_W-1:0]  cpuWdata,
  output logic               cpuReady,
  output logic               cpuRespValid,
  output logic [WORD_W-1:0]  cpuRdata,
  output logic               memReq,
  output logic               memWrite,
  output logic [LADDR_W-1:0] memAddr,
  output logic [LINE_W-1:0]  memWdata,
  input  logic               memReady,
  input  logic [LINE_W-1:0]  memRdata,
  output logic [CNT_W-1:0]   statPrimHits,
  output logic [CNT_W-1:0]   statVictimHits,
  output logic [CNT_W-1:0]   statMisses
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  vcache_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cpuValid (cpuValid),
    .status   (status),
    .memReady (memReady),
    .cpuReady (cpuReady),
    .memReq   (memReq),
    .memWrite (memWrite),
    .strobe   (strobe)
  );

  vcache_dp #(
    .ADDR_W     (ADDR_W),
    .WORD_W     (WORD_W),
    .LINE_WORDS (LINE_WORDS),
    .SETS       (SETS),
    .VB_DEPTH   (VB_DEPTH),
    .CNT_W      (CNT_W)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .cpuWrite   (cpuWrite),
    .cpuAddr    (cpuAddr),
    .cpuWdata   (cpuWdata),
    .strobe     (strobe),
    .status     (status),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .memRdata   (memRdata),
    .respValid  (cpuRespValid),
    .rdata      (cpuRdata),
    .cntPrimary (statPrimHits),
    .cntVictim  (statVictimHits),
    .cntMiss    (statMisses)
  );

  p_prim_resp_r2: assert property (@(posedge clk) disable iff (!rstN)
    cpuValid && cpuReady && status.primHit |=> cpuRespValid);

  p_vb_resp_r3: assert property (@(posedge clk) disable iff (!rstN)
    cpuValid && cpuReady && !status.primHit && status.vbHit |=> !cpuReady ##1 cpuRespValid);

  p_fill_resp_r4: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memWrite && memReady |=> cpuRespValid);

  p_mem_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> memReq && $stable(memWrite) && $stable(memAddr) && $stable(memWdata));

endmodule

// File: tb/victim_cache_test.sv
`timescale 1ns/1ps
module victim_cache_test;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cpuValid = 1'b0;
  logic         cpuWrite = 1'b0;
  logic [15:0]  cpuAddr = '0;
  logic [31:0]  cpuWdata = '0;
  logic         cpuReady, cpuRespValid;
  logic [31:0]  cpuRdata;
  logic         memReq, memWrite;
  logic [13:0]  memAddr;
  logic [127:0] memWdata;
  logic         memReady = 1'b0;
  logic [127:0] memRdata = '0;
  logic [15:0]  statPrimHits, statVictimHits, statMisses;

  always #2 clk = ~clk;

  victim_cache uut (
    .clk(clk), .rstN(rstN),
    .cpuValid(cpuValid), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuReady(cpuReady), .cpuRespValid(cpuRespValid), .cpuRdata(cpuRdata),
    .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr), .memWdata(memWdata),
    .memReady(memReady), .memRdata(memRdata),
    .statPrimHits(statPrimHits), .statVictimHits(statVictimHits), .statMisses(statMisses)
  );

  int nChecks = 0;
  int nFail = 0;
  int memReads = 0;
  int memWrites = 0;
  int protoErr = 0;
  int waitCnt = 0;
  logic [13:0] lastRdAddr = '0;
  logic [13:0] lastWbAddr = '0;
  logic [127:0] lineStore [int];
  logic [31:0]  refMem [int];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] memLine(input logic [13:0] la);
    logic [127:0] l;
    if (lineStore.exists(int'(la))) return lineStore[int'(la)];
    for (int w = 0; w < 4; w++) l[w*32 +: 32] = 32'hA000_0000 | {16'h0, la, w[1:0]};
    return l;
  endfunction

  function automatic logic [31:0] refRead(input logic [15:0] a);
    if (refMem.exists(int'(a))) return refMem[int'(a)];
    return 32'hA000_0000 | {16'h0, a};
  endfunction

  // lower-level memory: ready two cycles into a request
  initial begin
    forever begin
      @(negedge clk);
      if (memReady) begin
        memReady = 1'b0;
        waitCnt  = 0;
      end else if (memReq) begin
        waitCnt++;
        if (waitCnt == 2) begin
          memReady = 1'b1;
          if (memWrite) begin
            lineStore[int'(memAddr)] = memWdata;
            memWrites++;
            lastWbAddr = memAddr;
          end else begin
            memRdata = memLine(memAddr);
            memReads++;
            lastRdAddr = memAddr;
          end
        end
      end else if (waitCnt != 0) begin
        protoErr++;
        waitCnt = 0;
      end
    end
  end

  // cls: 0 primary hit, 1 buffer hit, 2 full miss; expWb: write-backs expected (-1 skip)
  task automatic access(input logic wr, input logic [15:0] addr, input logic [31:0] wd,
                        input int cls, input int expWb, input string req);
    int lat;
    int rd0, wr0;
    logic [15:0] p0, v0, m0;
    logic [31:0] expData;
    @(negedge clk);
    while (!cpuReady) @(negedge clk);
    rd0 = memReads; wr0 = memWrites;
    p0 = statPrimHits; v0 = statVictimHits; m0 = statMisses;
    cpuValid = 1'b1; cpuWrite = wr; cpuAddr = addr; cpuWdata = wd;
    @(negedge clk);
    cpuValid = 1'b0;
    lat = 1;
    if (cls == 1) check(cpuReady == 1'b0, req, "ready during swap", cpuReady, 0);
    while (!cpuRespValid && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    if (wr) refMem[int'(addr)] = wd;
    expData = refRead(addr);
    check(cpuRespValid && cpuRdata == expData, req, "response data", cpuRdata, expData);
    if (cls == 0) check(lat == 1, req, "hit latency", lat, 1);
    if (cls == 1) check(lat == 2, req, "buffer hit latency", lat, 2);
    if (cls == 2) check(lat >= 3, req, "miss latency", lat, 3);
    check(memReads - rd0 == (cls == 2 ? 1 : 0), req, "line reads", memReads - rd0, cls == 2 ? 1 : 0);
    if (expWb >= 0) check(memWrites - wr0 == expWb, req, "write-backs", memWrites - wr0, expWb);
    check(statPrimHits - p0 == (cls == 0 ? 1 : 0), req, "primary counter", statPrimHits - p0, cls == 0);
    check(statVictimHits - v0 == (cls == 1 ? 1 : 0), req, "buffer counter", statVictimHits - v0, cls == 1);
    check(statMisses - m0 == (cls == 2 ? 1 : 0), req, "miss counter", statMisses - m0, cls == 2);
  endtask

  task automatic testReset;
    // R1
    check(cpuReady == 1'b1, "R1", "ready", cpuReady, 1);
    check(cpuRespValid == 1'b0, "R1", "resp", cpuRespValid, 0);
    check(memReq == 1'b0, "R1", "memReq", memReq, 0);
    check(statPrimHits == 0 && statVictimHits == 0 && statMisses == 0, "R1", "counters",
          statPrimHits + statVictimHits + statMisses, 0);
  endtask

  task automatic testColdMiss;
    access(1'b0, 16'h0010, '0, 2, 0, "R4");
    check(lastRdAddr == 14'h0004, "R9", "line address", lastRdAddr, 14'h0004);
  endtask

  task automatic testPrimaryHit;
    access(1'b0, 16'h0012, '0, 0, 0, "R2");
    access(1'b1, 16'h0011, 32'h1111_0001, 0, 0, "R2");
    access(1'b0, 16'h0011, '0, 0, 0, "R2");
  endtask

  task automatic testSwap;
    access(1'b0, 16'h0030, '0, 2, 0, "R4");
    access(1'b0, 16'h0010, '0, 1, 0, "R3");
    access(1'b0, 16'h0011, '0, 0, 0, "R10");  // dirty word survived the swap
    access(1'b0, 16'h0030, '0, 1, 0, "R3");
  endtask

  task automatic testReplacement;
    // buffer holds line 4 (dirty); three free entries left
    access(1'b0, 16'h0050, '0, 2, 0, "R5");
    access(1'b0, 16'h0070, '0, 2, 0, "R5");
    access(1'b0, 16'h0090, '0, 2, 0, "R5");
    // buffer full: oldest entry is dirty line 4
    access(1'b0, 16'h00B0, '0, 2, 1, "R6");
    check(lastWbAddr == 14'h0004, "R6", "write-back address", lastWbAddr, 14'h0004);
    check(lineStore.exists(4) && lineStore[4][63:32] == 32'h1111_0001, "R10", "written word in memory",
          lineStore.exists(4) ? lineStore[4][63:32] : 0, 32'h1111_0001);
    // next oldest is clean line 0x0C: dropped
    access(1'b0, 16'h00D0, '0, 2, 0, "R6");
    access(1'b0, 16'h0050, '0, 1, 0, "R5");
    access(1'b0, 16'h0011, '0, 2, 0, "R10");
  endtask

  task automatic testWriteAllocate;
    access(1'b1, 16'h0205, 32'hCAFE_0205, 2, 0, "R7");
    access(1'b0, 16'h0205, '0, 0, 0, "R7");
    access(1'b0, 16'h0204, '0, 0, 0, "R7");
    check(!lineStore.exists(int'(16'h0205 >> 2)), "R7", "no early write", 1, 0);
    check(protoErr == 0, "R8", "request dropped before ready", protoErr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset;
    testColdMiss;
    testPrimaryHit;
    testSwap;
    testReplacement;
    testWriteAllocate;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule